// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block gates a differential CPU clock pair and a set of auxiliary clocks (reference, PCI, USB and a fixed mid-rate clock) under two active-low control pins. One pin requests power-down and the other requests that the CPU clock stop. Both pins are filtered by sampling them on successive CPU clock rising edges. A request counts only when every sample in the filter window reads low.

Each auxiliary clock has its own gate. The enable crosses into that clock's domain through a flop synchroniser, then passes through a latch that is transparent only while the clock is low. The gated clock therefore starts and stops only in its low phase. A per-domain status bit reports when the gated clock is parked.

The CPU pair is driven from the CPU clock domain. In place of tri-state, each pin has its own output-enable. Two configuration bits choose how the pair parks: one for power-down and one for CPU stop. After a stop is released, the pair waits a fixed number of CPU edges before it toggles again.

Top module: `clk_park_seq`

## Requirements
- R1: Power-down is accepted only after `pwrdn_n` reads low on two consecutive CPU rising edges. The pair changes at the second edge, and a pin that is low for one sample is ignored.
- R2: Each auxiliary gated clock stops and restarts only in its source's low phase. Every high pulse it emits is a full source half period.
- R3: `aux_parked[i]` is 1 only while `aux_out[i]` is low. During power-down all four `aux_parked` bits read 1 within 40 CPU cycles. Bit order is 0 reference, 1 PCI, 2 USB, 3 mid-rate.
- R4: In power-down with `cfg_pd_float_both`=0, `cpu_t` is driven (`cpu_t_oe`=1) at value 1 and `cpu_c_oe`=0.
- R5: In power-down with `cfg_pd_float_both`=1, both `cpu_t_oe` and `cpu_c_oe` are 0.
- R6: A CPU stop needs `cpustop_n` low on two consecutive CPU rising edges, and a one-sample low is ignored. With `cfg_stop_float`=0 the stopped pair is driven with `cpu_t`=1 and `cpu_c`=0, both enables at 1.
- R7: With `cfg_stop_float`=1 both enables are 0 while the CPU clock is stopped. From the first edge that samples `cpustop_n` high, the pair is driven with `cpu_t`=1 and `cpu_c`=0 until toggling resumes.
- R8: The pair follows the CPU clock again (`cpu_t`=`cpu_clk`, `cpu_c` its inverse, `cpu_parked`=0) at the 2nd CPU rising edge after the edge that first samples `cpustop_n` high.
- R9: Power-down outranks CPU stop. When both are requested, the pair parks as R4/R5 say.
- R10: While `rst_n` is low, `aux_out` is 0 and `aux_parked` is all 1. The pair is driven with `cpu_t`=1 and `cpu_c`=0, and `cpu_parked`=1.
- R11: The R1 latency is counted in CPU edges, so it is the same at a slower CPU clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | CPU clock source |
| aux_clk | input | NAUX | Auxiliary clock sources |
| pwrdn_n | input | 1 | Power-down request, active low |
| cpustop_n | input | 1 | CPU clock stop request, active low |
| cfg_pd_float_both | input | 1 | Power-down park: 0 drives true high, 1 releases both pins |
| cfg_stop_float | input | 1 | CPU stop park: 0 drives pair, 1 releases both pins |
| cpu_t | output | 1 | CPU true output value |
| cpu_c | output | 1 | CPU complement output value |
| cpu_t_oe | output | 1 | Output enable of CPU true pin |
| cpu_c_oe | output | 1 | Output enable of CPU complement pin |
| cpu_parked | output | 1 | CPU pair is not toggling |
| aux_out | output | NAUX | Gated auxiliary clocks |
| aux_parked | output | NAUX | Auxiliary gate closed, output held low |

## Verification
Power-down and CPU stop can be accepted on the same CPU edge. Some vectors pull both pins low together, with the two configuration bits set opposite to each other. The pair must then show the power-down park pattern and never the stop pattern. The pair's resume countdown can also overlap the reopening of the auxiliary gates when both pins are released at once. A continuous pulse-width monitor checks that no auxiliary pulse is cut short during that overlap, while the vector check confirms the pair toggles again.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

  // Drive state of the CPU pair, decoded each cycle from registered requests
  typedef enum logic [1:0] {
    PAIR_RUN  = 2'd0,
    PAIR_STOP = 2'd1,
    PAIR_WAKE = 2'd2,
    PAIR_PDN  = 2'd3
  } pair_mode_e;

  // Bit position of each auxiliary domain in the aux vectors
  localparam int unsigned AUX_REF = 0;
  localparam int unsigned AUX_PCI = 1;
  localparam int unsigned AUX_USB = 2;
  localparam int unsigned AUX_MID = 3;

endpackage

// File: rtl/cps_sync.sv
// Flop chain for a single bit. Used as a reset synchroniser (d tied high)
// and as an enable synchroniser into a clock domain.
module cps_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cps_aux_gate.sv
// One auxiliary domain: local reset release, enable synchroniser and a
// low-phase-transparent latch gate.
module cps_aux_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en_req,
  output logic gclk,
  output logic parked
);

  logic dom_rst_n;
  logic en_sync;
  logic en_lat;

  cps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .arst_n(arst_n), .d(1'b1), .q(dom_rst_n)
  );

  cps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en (
    .clk(clk), .arst_n(dom_rst_n), .d(en_req), .q(en_sync)
  );

  // Enable may only change while the source clock is low
  always_latch begin
    if (!dom_rst_n)  en_lat = 1'b0;
    else if (!clk)   en_lat = en_sync;
  end

  assign gclk   = clk & en_lat;
  assign parked = ~en_lat;

endmodule

// File: rtl/cps_pair_ctl.sv
// CPU-domain control: request filters, resume countdown and pair decode.
module cps_pair_ctl
  import clk_park_pkg::*;
#(
  parameter int unsigned DEB_SAMPLES = 2,
  parameter int unsigned RESUME_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic cpustop_n,
  input  logic cfg_pd_float_both,
  input  logic cfg_stop_float,
  output logic cpu_t,
  output logic cpu_c,
  output logic cpu_t_oe,
  output logic cpu_c_oe,
  output logic cpu_parked,
  output logic pd_req,
  output logic st_req,
  output logic aux_en
);

  localparam int unsigned WW = (RESUME_CYC > 1) ? $clog2(RESUME_CYC) : 1;
  localparam logic [WW-1:0] LOADV = WW'(RESUME_CYC - 1);

  logic [DEB_SAMPLES-1:0] pd_smp_q, pd_smp_d;
  logic [DEB_SAMPLES-1:0] st_smp_q, st_smp_d;
  logic [WW-1:0]          wait_q, wait_d;
  logic                   run_q, run_d;
  logic                   aux_en_q, aux_en_d;
  pair_mode_e             mode;

  // A request counts once every sample in the window read low
  assign pd_req = ~|pd_smp_q;
  assign st_req = ~|st_smp_q;

  always_comb begin
    pd_smp_d = {pd_smp_q[DEB_SAMPLES-2:0], pwrdn_n};
    st_smp_d = {st_smp_q[DEB_SAMPLES-2:0], cpustop_n};
    if (st_req)            wait_d = LOADV;
    else if (wait_q != '0) wait_d = wait_q - WW'(1);
    else                   wait_d = wait_q;
    run_d    = ~pd_req & ~st_req & (wait_q == '0);
    aux_en_d = ~pd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_smp_q <= '1;
      st_smp_q <= '1;
      wait_q   <= '0;
      run_q    <= 1'b0;
      aux_en_q <= 1'b0;
    end else begin
      pd_smp_q <= pd_smp_d;
      st_smp_q <= st_smp_d;
      wait_q   <= wait_d;
      run_q    <= run_d;
      aux_en_q <= aux_en_d;
    end
  end

  always_comb begin
    if (pd_req)      mode = PAIR_PDN;
    else if (st_req) mode = PAIR_STOP;
    else if (!run_q) mode = PAIR_WAKE;
    else             mode = PAIR_RUN;
  end

  // All updates land on rising edges, where true is high and complement low,
  // so moving between toggling and parked values cannot glitch.
  always_comb begin
    cpu_t    = 1'b1;
    cpu_c    = 1'b0;
    cpu_t_oe = 1'b1;
    cpu_c_oe = 1'b1;
    unique case (mode)
      PAIR_RUN: begin
        cpu_t = clk;
        cpu_c = ~clk;
      end
      PAIR_STOP: begin
        cpu_t_oe = ~cfg_stop_float;
        cpu_c_oe = ~cfg_stop_float;
      end
      PAIR_WAKE: begin
        cpu_t_oe = 1'b1;
      end
      PAIR_PDN: begin
        cpu_t_oe = ~cfg_pd_float_both;
        cpu_c_oe = 1'b0;
      end
      default: begin
        cpu_t_oe = 1'b1;
      end
    endcase
  end

  assign cpu_parked = (mode != PAIR_RUN);
  assign aux_en     = aux_en_q;

endmodule

// File: rtl/clk_park_seq.sv
module clk_park_seq
  import clk_park_pkg::*;
#(
  parameter int unsigned NAUX        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_SAMPLES = 2,
  parameter int unsigned RESUME_CYC  = 2
) (
  input  logic            rst_n,
  input  logic            cpu_clk,
  input  logic [NAUX-1:0] aux_clk,
  input  logic            pwrdn_n,
  input  logic            cpustop_n,
  input  logic            cfg_pd_float_both,
  input  logic            cfg_stop_float,
  output logic            cpu_t,
  output logic            cpu_c,
  output logic            cpu_t_oe,
  output logic            cpu_c_oe,
  output logic            cpu_parked,
  output logic [NAUX-1:0] aux_out,
  output logic [NAUX-1:0] aux_parked
);

  logic rst_cpu_n;
  logic pd_req;
  logic st_req;
  logic aux_en;

  cps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cpu_rst (
    .clk(cpu_clk), .arst_n(rst_n), .d(1'b1), .q(rst_cpu_n)
  );

  cps_pair_ctl #(.DEB_SAMPLES(DEB_SAMPLES), .RESUME_CYC(RESUME_CYC)) u_pair (
    .clk               (cpu_clk),
    .rst_n             (rst_cpu_n),
    .pwrdn_n           (pwrdn_n),
    .cpustop_n         (cpustop_n),
    .cfg_pd_float_both (cfg_pd_float_both),
    .cfg_stop_float    (cfg_stop_float),
    .cpu_t             (cpu_t),
    .cpu_c             (cpu_c),
    .cpu_t_oe          (cpu_t_oe),
    .cpu_c_oe          (cpu_c_oe),
    .cpu_parked        (cpu_parked),
    .pd_req            (pd_req),
    .st_req            (st_req),
    .aux_en            (aux_en)
  );

  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    cps_aux_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk    (aux_clk[g]),
      .arst_n (rst_n),
      .en_req (aux_en),
      .gclk   (aux_out[g]),
      .parked (aux_parked[g])
    );
  end

endmodule

// File: rtl/clk_park_seq_chk.sv
module clk_park_seq_chk #(
  parameter int unsigned NAUX = 4
) (
  input logic            rst_n,
  input logic            rst_cpu_n,
  input logic            cpu_clk,
  input logic [NAUX-1:0] aux_clk,
  input logic            pwrdn_n,
  input logic            pd_req,
  input logic            st_req,
  input logic            cfg_pd_float_both,
  input logic            cfg_stop_float,
  input logic            cpu_t,
  input logic            cpu_c,
  input logic            cpu_t_oe,
  input logic            cpu_c_oe,
  input logic [NAUX-1:0] aux_out,
  input logic [NAUX-1:0] aux_parked
);

  assert_pd_filter_R1: assert property (@(posedge cpu_clk) disable iff (!rst_cpu_n)
    $rose(pd_req) |-> (!$past(pwrdn_n, 1) && !$past(pwrdn_n, 2)));

  assert_pd_true_high_R4: assert property (@(posedge cpu_clk) disable iff (!rst_cpu_n)
    (pd_req && !cfg_pd_float_both) |-> (cpu_t_oe && cpu_t && !cpu_c_oe));

  assert_pd_both_free_R5: assert property (@(posedge cpu_clk) disable iff (!rst_cpu_n)
    (pd_req && cfg_pd_float_both) |-> (!cpu_t_oe && !cpu_c_oe));

  assert_stop_hold_R6: assert property (@(posedge cpu_clk) disable iff (!rst_cpu_n)
    (st_req && !pd_req && !cfg_stop_float) |-> (cpu_t && !cpu_c && cpu_t_oe && cpu_c_oe));

  assert_pd_over_stop_R9: assert property (@(posedge cpu_clk) disable iff (!rst_cpu_n)
    (pd_req && st_req) |-> !cpu_c_oe);

  for (genvar g = 0; g < NAUX; g++) begin : g_chk
    logic park_at_rise;

    always_ff @(posedge aux_clk[g]) begin
      park_at_rise <= aux_parked[g];
    end

    // Status seen at the rising edge must hold through the high phase
    assert_aux_no_runt_R2: assert property (@(negedge aux_clk[g]) disable iff (!rst_n)
      aux_parked[g] == park_at_rise);

    assert_aux_parked_low_R3: assert property (@(negedge aux_clk[g]) disable iff (!rst_n)
      aux_parked[g] |-> !aux_out[g]);
  end

endmodule

bind clk_park_seq clk_park_seq_chk #(.NAUX(NAUX)) u_chk (
  .rst_n             (rst_n),
  .rst_cpu_n         (rst_cpu_n),
  .cpu_clk           (cpu_clk),
  .aux_clk           (aux_clk),
  .pwrdn_n           (pwrdn_n),
  .pd_req            (pd_req),
  .st_req            (st_req),
  .cfg_pd_float_both (cfg_pd_float_both),
  .cfg_stop_float    (cfg_stop_float),
  .cpu_t             (cpu_t),
  .cpu_c             (cpu_c),
  .cpu_t_oe          (cpu_t_oe),
  .cpu_c_oe          (cpu_c_oe),
  .aux_out           (aux_out),
  .aux_parked        (aux_parked)
);

// File: tb/clk_park_seq_tb.sv
`timescale 1ns/1ps
module clk_park_seq_tb;

  logic       rst_n;
  logic       cpu_clk;
  logic [3:0] aux_clk;
  logic       pwrdn_n;
  logic       cpustop_n;
  logic       cfg_pd_float_both;
  logic       cfg_stop_float;
  logic       cpu_t, cpu_c, cpu_t_oe, cpu_c_oe, cpu_parked;
  logic [3:0] aux_out, aux_parked;

  int  n_chk;
  int  n_err;
  int  runt_err;
  int  park_err;
  bit  mon_on;
  real cpu_half;

  clk_park_seq u_dut (
    .rst_n(rst_n), .cpu_clk(cpu_clk), .aux_clk(aux_clk),
    .pwrdn_n(pwrdn_n), .cpustop_n(cpustop_n),
    .cfg_pd_float_both(cfg_pd_float_both), .cfg_stop_float(cfg_stop_float),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe),
    .cpu_parked(cpu_parked), .aux_out(aux_out), .aux_parked(aux_parked)
  );

  initial begin
    cpu_half = 4.0;
    cpu_clk  = 1'b0;
    forever #(cpu_half) cpu_clk = ~cpu_clk;
  end
  initial begin aux_clk[0] = 1'b0; forever #35.0 aux_clk[0] = ~aux_clk[0]; end
  initial begin aux_clk[1] = 1'b0; forever #15.0 aux_clk[1] = ~aux_clk[1]; end
  initial begin aux_clk[2] = 1'b0; forever #10.5 aux_clk[2] = ~aux_clk[2]; end
  initial begin aux_clk[3] = 1'b0; forever #7.5  aux_clk[3] = ~aux_clk[3]; end

  function automatic real aux_half(input int i);
    case (i)
      0:       aux_half = 35.0;
      1:       aux_half = 15.0;
      2:       aux_half = 10.5;
      default: aux_half = 7.5;
    endcase
  endfunction

  // Pulse-width and status monitor on the gated auxiliary clocks (R2, R3)
  logic [3:0] prev_out;
  real        t_up [4];
  always @(aux_out or aux_parked) begin
    for (int i = 0; i < 4; i++) begin
      if (mon_on && aux_parked[i] && aux_out[i]) park_err++;
      if (aux_out[i] === 1'b1 && prev_out[i] !== 1'b1) t_up[i] = $realtime;
      if (aux_out[i] === 1'b0 && prev_out[i] === 1'b1 && mon_on) begin
        real w;
        w = $realtime - t_up[i] - aux_half(i);
        if (w > 0.01 || w < -0.01) runt_err++;
      end
    end
    prev_out = aux_out;
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge cpu_clk);
    #1;
  endtask

  function automatic logic [8:0] bundle();
    return {cpu_t, cpu_c, cpu_t_oe, cpu_c_oe, cpu_parked, aux_parked};
  endfunction

  // {pwrdn_n, cpustop_n, cfg_pd_float_both, cfg_stop_float,
  //  t, c, t_oe, c_oe, cpu_parked, aux_parked[3:0]}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    13'b1100_0111_0_0000, // R8 running
    13'b1000_1011_1_0000, // R6 stop, pair driven
    13'b1001_1000_1_0000, // R7 stop, pair released
    13'b1100_0111_0_0000, // R8 running again
    13'b0100_1010_1_1111, // R4 power-down, true high
    13'b0110_1000_1_1111, // R5 power-down, both released
    13'b0001_1010_1_1111, // R9 both requested, stop-float ignored
    13'b1100_0111_0_0000, // R2 restart of all domains
    13'b0010_1000_1_1111, // R9 both requested, pd-float
    13'b1100_0111_0_0000  // R3 status clears on restart
  };
  localparam int VREQ [NV] = '{8, 6, 7, 8, 4, 5, 9, 2, 9, 3};

  initial begin
    n_chk = 0; n_err = 0; runt_err = 0; park_err = 0; mon_on = 1'b0;
    rst_n = 1'b0; pwrdn_n = 1'b1; cpustop_n = 1'b1;
    cfg_pd_float_both = 1'b0; cfg_stop_float = 1'b0;

    // R10 reset state
    step(20);
    chk("R10", "reset pair/status", {7'd0, bundle()}, {7'd0, 9'b1011_1_1111});
    chk("R10", "reset aux_out", {12'd0, aux_out}, 16'h0000);
    rst_n = 1'b1;
    step(40);
    mon_on = 1'b1;

    for (int v = 0; v < NV; v++) begin
      {pwrdn_n, cpustop_n, cfg_pd_float_both, cfg_stop_float} = VEC[v][12:9];
      step(40);
      n_chk++;
      if (bundle() !== VEC[v][8:0]) begin
        n_err++;
        $display("FAIL R%0d vector %0d: actual %b expected %b", VREQ[v], v, bundle(), VEC[v][8:0]);
      end
    end

    // R1 latency: second low sample parks the pair
    pwrdn_n = 1'b0;
    step(1);
    chk("R1", "after first low sample c_oe", {15'd0, cpu_c_oe}, 16'd1);
    step(1);
    chk("R1", "after second low sample c_oe", {15'd0, cpu_c_oe}, 16'd0);
    pwrdn_n = 1'b1;
    step(40);

    // R1 single low sample ignored
    begin
      int bad;
      bad = 0;
      pwrdn_n = 1'b0;
      step(1);
      pwrdn_n = 1'b1;
      for (int k = 0; k < 40; k++) begin
        if (!cpu_c_oe || aux_parked != 4'b0000) bad++;
        step(1);
      end
      chk("R1", "one-sample power-down pulse", bad[15:0], 16'd0);
    end

    // R6 single low sample on stop ignored
    begin
      int bad;
      bad = 0;
      cpustop_n = 1'b0;
      step(1);
      cpustop_n = 1'b1;
      for (int k = 0; k < 10; k++) begin
        if (cpu_parked) bad++;
        step(1);
      end
      chk("R6", "one-sample stop pulse", bad[15:0], 16'd0);
    end

    // R6/R7/R8 stop entry and timed resume with released pins
    cfg_stop_float = 1'b1;
    cpustop_n = 1'b0;
    step(1);
    chk("R6", "after first stop sample parked", {15'd0, cpu_parked}, 16'd0);
    step(1);
    chk("R7", "stopped pair released", {14'd0, cpu_t_oe, cpu_c_oe}, 16'd0);
    step(8);
    cpustop_n = 1'b1;
    step(1);
    chk("R7", "driven high after release", {12'd0, cpu_t, cpu_c, cpu_t_oe, cpu_c_oe}, 16'b1011);
    step(1);
    chk("R8", "still parked one edge later", {14'd0, cpu_t, cpu_parked}, 16'b11);
    step(1);
    chk("R8", "toggling at second edge", {13'd0, cpu_t, cpu_c, cpu_parked}, 16'b010);
    cfg_stop_float = 1'b0;
    step(10);

    // R11 same edge latency at a slower CPU clock
    cpu_half = 7.5;
    step(10);
    pwrdn_n = 1'b0;
    step(1);
    chk("R11", "slow clock first sample c_oe", {15'd0, cpu_c_oe}, 16'd1);
    step(1);
    chk("R11", "slow clock second sample c_oe", {15'd0, cpu_c_oe}, 16'd0);
    pwrdn_n = 1'b1;
    step(30);

    chk("R2", "runt pulses seen", runt_err[15:0], 16'd0);
    chk("R3", "parked while high", park_err[15:0], 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule